// File: doc/BRIEF.md
# Snapshot Tick Counter

This block keeps a free-running 64-bit count of time-base ticks and lets software see that count through a 32-bit register bus. The running count is never read directly. Software writes a command into a control register, and the block copies the full 64-bit count into a pair of 32-bit shadow words in a single cycle. Software then reads those words one at a time at its own pace, and the two halves always belong to the same instant.

The control register carries two command bits that clear themselves. The latch command takes a snapshot of the count. The clear command zeroes both shadow words. When both bits are written together, the latch is applied first and the clear second, so the result is zero. Software may also write either shadow word directly. Such a write never disturbs the running count. Every other control bit is kept as written and reads back unchanged.

Bus map, word-addressed: address 0 is control, address 1 is the low shadow word (count bits 31:0), address 2 is the high shadow word (count bits 63:32), and address 3 is unused. Reads are combinational and have no side effects.

Top module: `snapcnt_top`

## Requirements
- R1: After a cycle with `rst_n` low, the control word, both shadow words and the running count are all 0.
- R2: The running count goes up by exactly 1 at each rising clock edge where `tick_en` is 1, and holds where it is 0.
- R3: A write to address 0 with bit 1 (latch) set and bit 0 clear loads the low word with count bits 31:0 and the high word with count bits 63:32. The value loaded is the count held just before that clock edge, and it is visible from the next cycle.
- R4: A write to address 0 with bit 0 (clear) set makes both shadow words 0 from the next cycle.
- R5: A write to address 0 with bits 1 and 0 both set leaves both shadow words at 0.
- R6: After any write to address 0, reading address 0 returns the written value with bits 1 and 0 forced to 0.
- R7: A write to address 1 replaces only the low word, and a write to address 2 replaces only the high word. Neither write changes the running count seen by a later latch.
- R8: A read of address 3 returns 0, and a write to address 3 changes no register.
- R9: A cycle with `bus_wr` low, or a write to address 0 with bits 1 and 0 both clear, leaves both shadow words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Time-base enable; the count advances on each edge where it is high |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 2 | Word address (0 control, 1 low word, 2 high word, 3 unused) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The bench first goes after the ordering of the two command bits. A design that applied the clear before the latch would leave a non-zero snapshot when both bits are written together. It then issues a latch in the same cycle that `tick_en` is high. A design that captured the count after the increment would read one higher than the model. Next it writes the shadow words directly and latches again afterwards. A design that shared storage between the shadow words and the running count would lose ticks or show the written value. Last, it checks that the command bits read back as 0 while the other control bits are kept, and that address 3 neither reads back data nor disturbs any register.

// File: rtl/snapcnt_pkg.sv
// Shared constants and types for the snapshot tick counter.
// Assumes a word-addressed register bus with the control word at address 0
// and the shadow words at consecutive addresses after it.
package snapcnt_pkg;

    // Bit positions of the self-clearing command bits in the control word.
    localparam int CMD_CLEAR_POS = 0;
    localparam int CMD_LATCH_POS = 1;

    // Word addresses.
    localparam int CTRL_ADDR      = 0;
    localparam int WORD_BASE_ADDR = 1;

    // One-cycle command pulses decoded from a control write.
    typedef struct packed {
        logic latch;
        logic clear;
    } snap_cmd_t;

endpackage

// File: rtl/snapcnt_timebase.sv
// Free-running tick counter.
// It advances by one on each clock edge where tick_en is high. It wraps
// naturally at 2**CNT_W. It assumes tick_en is synchronous to clk.
module snapcnt_timebase #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count_q
);

    // Count enabled ticks; zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_en) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/snapcnt_ctrl.sv
// Control word register.
// It stores every control bit except the two command bits. Those are turned
// into one-cycle pulses and never stored, so they always read back as 0.
// It assumes wr_ctrl is already qualified by the address decode.
module snapcnt_ctrl
    import snapcnt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output snap_cmd_t         cmd
);

    localparam logic [DATA_W-1:0] CMD_BITS =
        (DATA_W'(1) << CMD_CLEAR_POS) | (DATA_W'(1) << CMD_LATCH_POS);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~CMD_BITS;

    // Decode the command pulses from the current write.
    always_comb begin
        cmd.latch = wr_ctrl & wdata[CMD_LATCH_POS];
        cmd.clear = wr_ctrl & wdata[CMD_CLEAR_POS];
    end

    // Store the non-command bits of a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata & KEEP_MASK;
        end
    end

endmodule

// File: rtl/snapcnt_shadow.sv
// Shadow words that hold the snapshot of the running count.
// Each word has its own register and its own direct-write strobe. Clear has
// priority over latch, which has priority over a direct write. This gives the
// latch-then-clear result when both commands arrive together. It assumes at
// most one of word_wr and a command is active in any cycle.
module snapcnt_shadow
    import snapcnt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 2,
    localparam int CNT_W    = DATA_W * NUM_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  snap_cmd_t            cmd,
    input  logic [NUM_WORDS-1:0] word_wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [CNT_W-1:0]     count_val,
    output logic [CNT_W-1:0]     snap_q
);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Update one shadow word from a clear, a latch or a direct write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (cmd.clear) begin
                word_q <= '0;
            end else if (cmd.latch) begin
                word_q <= count_val[k*DATA_W +: DATA_W];
            end else if (word_wr[k]) begin
                word_q <= wdata;
            end
        end

        assign snap_q[k*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/snapcnt_rdmux.sv
// Read-data multiplexer.
// It selects the control word or one shadow word by address. Any unmapped
// address reads as 0. It is purely combinational and has no side effects.
module snapcnt_rdmux
    import snapcnt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 2,
    localparam int CNT_W    = DATA_W * NUM_WORDS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [CNT_W-1:0]  snap,
    output logic [DATA_W-1:0] rdata
);

    // Pick the addressed word, defaulting to zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata = ctrl_q;
        end
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (addr == ADDR_W'(WORD_BASE_ADDR + k)) begin
                rdata = snap[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/snapcnt_top.sv
// Snapshot tick counter, top level.
// A free-running counter of width DATA_W*NUM_WORDS is copied into shadow
// words by a self-clearing latch command and zeroed by a self-clearing clear
// command, both given in the control word. It assumes a single-cycle write
// strobe and combinational reads.
module snapcnt_top
    import snapcnt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int CNT_W = DATA_W * NUM_WORDS;

    logic [CNT_W-1:0]     time_q;
    logic [CNT_W-1:0]     snap_q;
    logic [DATA_W-1:0]    ctrl_q;
    logic [NUM_WORDS-1:0] word_wr;
    logic                 wr_ctrl;
    snap_cmd_t            cmd;

    // Address decode for the control word.
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    // Address decode for each shadow word.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_dec
        assign word_wr[k] = bus_wr && (bus_addr == ADDR_W'(WORD_BASE_ADDR + k));
    end

    snapcnt_timebase #(.CNT_W(CNT_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count_q (time_q)
    );

    snapcnt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .cmd     (cmd)
    );

    snapcnt_shadow #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .word_wr   (word_wr),
        .wdata     (bus_wdata),
        .count_val (time_q),
        .snap_q    (snap_q)
    );

    snapcnt_rdmux #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_rd (
        .addr   (bus_addr),
        .ctrl_q (ctrl_q),
        .snap   (snap_q),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/snapcnt_chk.sv
// Property checker for the snapshot tick counter.
// It is attached to snapcnt_top by the bind below and observes the running
// count, the shadow words and the control word.
module snapcnt_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  time_q,
    input logic [CNT_W-1:0]  snap_q,
    input logic [DATA_W-1:0] ctrl_q
);

    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == '0);

    // R1: state is zero in the first cycle after reset is released.
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (time_q == '0 && snap_q == '0 && ctrl_q == '0));

    // R2: each enabled tick adds exactly one.
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> time_q == $past(time_q) + 1'b1);

    // R2: the count holds without a tick.
    p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(time_q));

    // R3: a latch alone captures the pre-edge count.
    p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[1] && !bus_wdata[0]) |=> snap_q == $past(time_q));

    // R4, R5: any write with the clear bit leaves the snapshot at zero.
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[0]) |=> snap_q == '0);

    // R6: control stores the written value with the command bits dropped.
    p_ctrl_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q[DATA_W-1:2] == $past(bus_wdata[DATA_W-1:2]) && ctrl_q[1:0] == 2'b00));

    // R9: an idle bus leaves the snapshot and control unchanged.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(snap_q) && $stable(ctrl_q)));

    // R8: a write to the unused address changes no register.
    p_unused_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '1) |=> ($stable(snap_q) && $stable(ctrl_q)));

endmodule

bind snapcnt_top snapcnt_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .time_q    (time_q),
    .snap_q    (snap_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/sim_snapcnt_top.sv
// Bench for snapcnt_top.
// A behavioural model is updated at every rising edge and compared with the
// read data two time units later. Directed reads add fixed expected values.
module sim_snapcnt_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Model state.
    bit [63:0] m_time;
    bit [31:0] m_ctrl, m_lo, m_hi;

    always #5 clk = ~clk;

    snapcnt_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic bit [31:0] mread(input logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return m_lo;
            2'd2:    return m_hi;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update at each edge, then a compare of the current read.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = '0; m_ctrl = '0; m_lo = '0; m_hi = '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: begin
                        m_ctrl = bus_wdata & ~32'h3;
                        if (bus_wdata[1]) begin m_lo = m_time[31:0]; m_hi = m_time[63:32]; end
                        if (bus_wdata[0]) begin m_lo = '0; m_hi = '0; end
                    end
                    2'd1: m_lo = bus_wdata;
                    2'd2: m_hi = bus_wdata;
                    default: ;
                endcase
            end
            if (tick_en) m_time = m_time + 64'd1;
        end
        #2;
        if (!done) chk((bus_addr == 2'd0) ? "R6 model" : (bus_addr == 2'd3) ? "R8 model" : "R3 model",
                       bus_rdata, mread(bus_addr));
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog for all requirements actual=timeout expected=done");
        finish_run();
    end

    // Stimulus.
    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rd(2'd0, 32'h0, "R1 ctrl");
        rd(2'd1, 32'h0, "R1 low");
        rd(2'd2, 32'h0, "R1 high");
        rst_n = 1'b1;

        // R2/R3: ten ticks, then a latch with the time base idle.
        @(negedge clk); tick_en = 1'b1;
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        wr(2'd0, 32'h2);
        rd(2'd1, 32'd10, "R2 R3 low after 10 ticks");
        rd(2'd2, 32'd0, "R3 high");
        rd(2'd0, 32'h0, "R6 latch bit self-clears");

        // R5/R6: both command bits together give zero; other bits are kept.
        @(negedge clk); tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        wr(2'd0, 32'hA5A5_0003);
        rd(2'd1, 32'h0, "R5 low");
        rd(2'd2, 32'h0, "R5 high");
        rd(2'd0, 32'hA5A5_0000, "R6 ctrl readback");

        // R7: direct writes to each word.
        wr(2'd1, 32'hDEAD_BEEF);
        rd(2'd1, 32'hDEAD_BEEF, "R7 low write");
        rd(2'd2, 32'h0, "R7 high untouched");
        wr(2'd2, 32'hCAFE_F00D);
        rd(2'd2, 32'hCAFE_F00D, "R7 high write");
        rd(2'd1, 32'hDEAD_BEEF, "R7 low untouched");

        // R9: a control write without commands leaves the words alone.
        wr(2'd0, 32'h0000_0010);
        rd(2'd1, 32'hDEAD_BEEF, "R9 low held");
        rd(2'd2, 32'hCAFE_F00D, "R9 high held");
        rd(2'd0, 32'h0000_0010, "R6 plain ctrl");

        // R8: the unused address reads 0 and ignores writes.
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 32'h0, "R8 read");
        rd(2'd1, 32'hDEAD_BEEF, "R8 low held");
        rd(2'd0, 32'h0000_0010, "R8 ctrl held");

        // R7: the running count is unaffected by the direct writes.
        wr(2'd0, 32'h2);
        rd(2'd1, 32'd15, "R7 count intact");
        rd(2'd2, 32'd0, "R7 high from count");

        // R3: a latch in a tick cycle captures the pre-increment value.
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h2;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(2'd1, 32'd15, "R3 pre-increment capture");
        wr(2'd0, 32'h2);
        rd(2'd1, 32'd16, "R2 tick after latch");

        // R4: clear alone.
        wr(2'd0, 32'h1);
        rd(2'd1, 32'h0, "R4 low");
        rd(2'd2, 32'h0, "R4 high");
        rd(2'd0, 32'h0, "R4 ctrl");

        // Mixed traffic, checked against the model every cycle.
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick_en   = lfsr[0] | lfsr[3];
            bus_wr    = (lfsr[5:4] == 2'b11);
            bus_addr  = lfsr[7:6];
            bus_wdata = {lfsr, lfsr[15:8], 6'h0, (lfsr[9] & lfsr[1]), lfsr[2]};
        end
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule